// File: doc/BRIEF.md
# Drive Interface Status Gating

This block sits between a floppy drive's sensor conditioning and the shared host cable. It takes the index detector pulse, the write-protect switch level, the qualified track-zero indication, the active-low select line, the multiplex-mode jumper and the host write-gate request. Each of these passes through a two-flop synchronizer. The block then presents active-low index, write-protect and track-zero status to the interface. That status is driven only while this drive is selected. When the drive is not selected, every interface output rests high, so several drives can share one cable.

Internally the block produces three more signals. The first is a write-enable permission, which a set write-protect switch always blocks. The second is an electronics-enable, which the multiplex jumper can hold on while the drive is unselected. The third is the front-panel LED, which lights only when the drive is selected. A revolution monitor counts a 1 kHz tick strobe between rising edges of the index signal. It flags a fault when no edge arrives in time, or when an edge arrives too early. All control and status pins are plain levels; there is no streaming data path.

Top module: `dsg_status_gate`

## Requirements
- R1: `index_n` is low exactly when the drive is selected (`sel_n` low) and `index_det` is high; otherwise it is high.
- R2: `wprot_n` is low exactly when the drive is selected and `wprot_sw` is high (high means protected).
- R3: `trk0_n` is low exactly when the drive is selected and `trk0_ok` is high.
- R4: While `sel_n` is high, `index_n`, `wprot_n` and `trk0_n` are all high, whatever the sensor inputs are.
- R5: `wr_en` is high only when the drive is selected, `wgate_req` is high and `wprot_sw` is low. A high `wprot_sw` forces `wr_en` low, selected or not.
- R6: `elec_en` is high when the drive is selected or `mux_jmp` is high.
- R7: `led_on` is high exactly when the drive is selected. With `mux_jmp` high and the drive unselected, `elec_en` is high and `led_on` is low.
- R8: Every output is registered. A steady change on an input appears at the outputs three clock cycles later: two synchronizer stages and one output register. Reset state: `index_n`, `wprot_n` and `trk0_n` are high; `wr_en`, `elec_en`, `led_on` and `index_fault` are low.
- R9: `index_fault` rises when TIMEOUT_TICKS ticks (default 250) pass with no index rising edge. A rising edge that arrives after the count has reached that limit leaves the fault set.
- R10: `index_fault` rises when an index rising edge follows the previous one by fewer than MIN_TICKS ticks (default 150).
- R11: `index_fault` clears on an index rising edge whose interval is at least MIN_TICKS and below TIMEOUT_TICKS.
- R12: The first index rising edge after reset never raises the short-interval fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1k | input | 1 | One-cycle 1 kHz timing strobe, synchronous to clk |
| index_det | input | 1 | Index detector pulse, high while the hole passes |
| wprot_sw | input | 1 | Write-protect switch level, high means protected |
| trk0_ok | input | 1 | Qualified track-zero indication, high at track zero |
| sel_n | input | 1 | Drive select, active low, idles high |
| mux_jmp | input | 1 | Multiplex-mode jumper, high keeps electronics on when unselected |
| wgate_req | input | 1 | Host write-gate request, active high |
| index_n | output | 1 | Interface index status, active low |
| wprot_n | output | 1 | Interface write-protect status, active low |
| trk0_n | output | 1 | Interface track-zero status, active low |
| wr_en | output | 1 | Internal write-enable permission |
| elec_en | output | 1 | Internal drive electronics enable |
| led_on | output | 1 | Front-panel activity LED drive |
| index_fault | output | 1 | Revolution monitor fault flag |

## Verification
The hardest states to reach from the ports are the revolution monitor's faults. A timeout needs hundreds of ticks with no index edge, and a short interval needs one complete good revolution before it. The bench therefore strobes `tick_1k` once every four clocks and places index pulses at chosen tick counts. It runs starvation first, then a late edge that must leave the fault set, then a good period, a short period and a recovery. A reset followed at once by an early pulse shows that the first edge raises no fault.

// File: rtl/dsg_pkg.sv
package dsg_pkg;

  // Synchronized view of the asynchronous inputs.
  typedef struct packed {
    logic idx;
    logic wp;
    logic trk0;
    logic sel_n;
    logic mux;
    logic wgate;
  } drv_in_t;

  localparam int DRV_IN_W = $bits(drv_in_t);

  // Idle levels: select line pulled high, everything else low.
  localparam drv_in_t DRV_IN_IDLE = '{idx: 1'b0, wp: 1'b0, trk0: 1'b0,
                                      sel_n: 1'b1, mux: 1'b0, wgate: 1'b0};

endpackage

// File: rtl/dsg_sync.sv
module dsg_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage_chk
      AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        chain[g] == $past(chain[g-1])); // R8
    end
  endgenerate

endmodule

// File: rtl/dsg_gate.sv
module dsg_gate
  import dsg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  drv_in_t s,
  output logic    index_n,
  output logic    wprot_n,
  output logic    trk0_n,
  output logic    wr_en,
  output logic    elec_en,
  output logic    led_on
);

  logic sel;
  assign sel = ~s.sel_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_n <= 1'b1;
      wprot_n <= 1'b1;
      trk0_n  <= 1'b1;
      wr_en   <= 1'b0;
      elec_en <= 1'b0;
      led_on  <= 1'b0;
    end else begin
      index_n <= ~(s.idx  & sel);
      wprot_n <= ~(s.wp   & sel);
      trk0_n  <= ~(s.trk0 & sel);
      wr_en   <= sel & s.wgate & ~s.wp;
      elec_en <= sel | s.mux;
      led_on  <= sel;
    end
  end

  AST_UNSEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    s.sel_n |=> (index_n && wprot_n && trk0_n)); // R4
  AST_WP_BLOCKS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    s.wp |=> !wr_en); // R5
  AST_ELEC_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (sel || s.mux) |=> elec_en); // R6
  AST_MUX_LED_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (s.sel_n && s.mux) |=> (elec_en && !led_on)); // R7

endmodule

// File: rtl/dsg_idx_mon.sv
module dsg_idx_mon #(
  parameter int TIMEOUT_TICKS = 250,
  parameter int MIN_TICKS     = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic idx_s,
  output logic fault
);

  localparam int CW = $clog2(TIMEOUT_TICKS + 1);
  localparam logic [CW-1:0] LIM  = CW'(TIMEOUT_TICKS);
  localparam logic [CW-1:0] LIM1 = CW'(TIMEOUT_TICKS - 1);
  localparam logic [CW-1:0] MINV = CW'(MIN_TICKS);

  logic [CW-1:0] cnt;
  logic          idx_d;
  logic          seen;
  logic          rise;

  assign rise = idx_s & ~idx_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      idx_d <= 1'b0;
      seen  <= 1'b0;
      fault <= 1'b0;
    end else begin
      idx_d <= idx_s;
      if (rise) begin
        cnt  <= '0;
        seen <= 1'b1;
        if (cnt >= LIM) fault <= fault;
        else if (seen && cnt < MINV) fault <= 1'b1;
        else if (cnt >= MINV) fault <= 1'b0;
      end else if (tick && cnt != LIM) begin
        cnt <= cnt + 1'b1;
        if (cnt == LIM1) fault <= 1'b1;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM); // R9
  AST_TIMEOUT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !rise && cnt == LIM1) |=> fault); // R9
  AST_SHORT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && seen && cnt < MINV) |=> fault); // R10
  AST_GOOD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && cnt >= MINV && cnt < LIM) |=> !fault); // R11
  AST_FIRST_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !seen && !fault) |=> !fault); // R12

endmodule

// File: rtl/dsg_status_gate.sv
module dsg_status_gate
  import dsg_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int TIMEOUT_TICKS = 250,
  parameter int MIN_TICKS     = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1k,
  input  logic index_det,
  input  logic wprot_sw,
  input  logic trk0_ok,
  input  logic sel_n,
  input  logic mux_jmp,
  input  logic wgate_req,
  output logic index_n,
  output logic wprot_n,
  output logic trk0_n,
  output logic wr_en,
  output logic elec_en,
  output logic led_on,
  output logic index_fault
);

  drv_in_t raw;
  drv_in_t syn;

  assign raw = '{idx: index_det, wp: wprot_sw, trk0: trk0_ok,
                 sel_n: sel_n, mux: mux_jmp, wgate: wgate_req};

  dsg_sync #(
    .WIDTH  (DRV_IN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(DRV_IN_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw),
    .q    (syn)
  );

  dsg_gate u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .s      (syn),
    .index_n(index_n),
    .wprot_n(wprot_n),
    .trk0_n (trk0_n),
    .wr_en  (wr_en),
    .elec_en(elec_en),
    .led_on (led_on)
  );

  dsg_idx_mon #(
    .TIMEOUT_TICKS(TIMEOUT_TICKS),
    .MIN_TICKS    (MIN_TICKS)
  ) u_mon (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_1k),
    .idx_s(syn.idx),
    .fault(index_fault)
  );

endmodule

// File: tb/sim_dsg_status_gate.sv
module sim_dsg_status_gate;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1k = 1'b0;
  logic index_det = 1'b0, wprot_sw = 1'b0, trk0_ok = 1'b0;
  logic sel_n = 1'b1, mux_jmp = 1'b0, wgate_req = 1'b0;
  logic index_n, wprot_n, trk0_n, wr_en, elec_en, led_on, index_fault;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  dsg_status_gate u0 (
    .clk(clk), .rst_n(rst_n), .tick_1k(tick_1k),
    .index_det(index_det), .wprot_sw(wprot_sw), .trk0_ok(trk0_ok),
    .sel_n(sel_n), .mux_jmp(mux_jmp), .wgate_req(wgate_req),
    .index_n(index_n), .wprot_n(wprot_n), .trk0_n(trk0_n),
    .wr_en(wr_en), .elec_en(elec_en), .led_on(led_on),
    .index_fault(index_fault)
  );

  // Tick strobe: one cycle high in every four.
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv    <= (tdiv == 3) ? 0 : tdiv + 1;
    tick_1k <= (tdiv == 3);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse_index();
    index_det = 1'b1;
    repeat (8) @(negedge clk);
    index_det = 1'b0;
  endtask

  task automatic t_reset_state();
    check(index_n && wprot_n && trk0_n, "R8 reset iface", {index_n, wprot_n, trk0_n}, 7);
    check(!wr_en && !elec_en && !led_on && !index_fault, "R8 reset internal",
          {wr_en, elec_en, led_on, index_fault}, 0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    sel_n = 1'b0;
    repeat (2) @(negedge clk);
    check(led_on == 1'b0, "R8 not yet after 2 cycles", led_on, 0);
    @(negedge clk);
    check(led_on == 1'b1, "R8 visible after 3 cycles", led_on, 1);
    sel_n = 1'b1; settle();
  endtask

  task automatic t_gating();
    sel_n = 1'b0; index_det = 1'b1; wprot_sw = 1'b1; trk0_ok = 1'b1; settle();
    check(index_n == 0, "R1 index selected", index_n, 0);
    check(wprot_n == 0, "R2 wprot selected", wprot_n, 0);
    check(trk0_n == 0, "R3 trk0 selected", trk0_n, 0);
    index_det = 1'b0; wprot_sw = 1'b0; trk0_ok = 1'b0; settle();
    check(index_n && wprot_n && trk0_n, "R1 R2 R3 inputs low", {index_n, wprot_n, trk0_n}, 7);
    sel_n = 1'b1; index_det = 1'b1; wprot_sw = 1'b1; trk0_ok = 1'b1; settle();
    check(index_n && wprot_n && trk0_n, "R4 unselected idle", {index_n, wprot_n, trk0_n}, 7);
    index_det = 1'b0; wprot_sw = 1'b0; trk0_ok = 1'b0; settle();
  endtask

  task automatic t_write();
    sel_n = 1'b0; wgate_req = 1'b1; settle();
    check(wr_en == 1, "R5 write allowed", wr_en, 1);
    wprot_sw = 1'b1; settle();
    check(wr_en == 0, "R5 protect blocks selected", wr_en, 0);
    sel_n = 1'b1; settle();
    check(wr_en == 0, "R5 protect blocks unselected", wr_en, 0);
    wprot_sw = 1'b0; settle();
    check(wr_en == 0, "R5 unselected no write", wr_en, 0);
    wgate_req = 1'b0; sel_n = 1'b0; settle();
    check(wr_en == 0, "R5 no request", wr_en, 0);
    sel_n = 1'b1; settle();
  endtask

  task automatic t_select_mux();
    sel_n = 1'b0; mux_jmp = 1'b0; settle();
    check(elec_en && led_on, "R6 R7 selected", {elec_en, led_on}, 3);
    sel_n = 1'b1; settle();
    check(!elec_en && !led_on, "R6 R7 unselected", {elec_en, led_on}, 0);
    mux_jmp = 1'b1; settle();
    check(elec_en && !led_on, "R7 mux unselected", {elec_en, led_on}, 2);
    sel_n = 1'b0; settle();
    check(elec_en && led_on, "R6 mux selected", {elec_en, led_on}, 3);
    sel_n = 1'b1; mux_jmp = 1'b0; settle();
  endtask

  task automatic t_monitor();
    do_reset();
    wait_ticks(240);
    check(index_fault == 0, "R9 before timeout", index_fault, 0);
    wait_ticks(30);
    check(index_fault == 1, "R9 timeout", index_fault, 1);
    pulse_index(); settle();
    check(index_fault == 1, "R9 late edge keeps fault", index_fault, 1);
    wait_ticks(196);
    pulse_index(); settle();
    check(index_fault == 0, "R11 good period clears", index_fault, 0);
    wait_ticks(48);
    pulse_index(); settle();
    check(index_fault == 1, "R10 short period", index_fault, 1);
    wait_ticks(196);
    pulse_index(); settle();
    check(index_fault == 0, "R11 recovery", index_fault, 0);
    do_reset();
    wait_ticks(20);
    pulse_index(); settle();
    check(index_fault == 0, "R12 first edge", index_fault, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset_state();
    t_latency();
    t_gating();
    t_write();
    t_select_mux();
    t_monitor();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule